// File: doc/BRIEF.md
# Key-Driven Shuffled Address Generator

This block produces the sequence of cover-word addresses consumed while message bits are being hidden in a large memory. Rather than stepping linearly through memory, it keeps a bank of independent pointer counters and lets a byte of the secret key decide which counter supplies the next address. The result is an address order that only a holder of the key can reproduce.

Each request presents one key byte. The low bits of that byte select one counter out of the bank. The selected counter's current value is combined with its index and with the upper key bits into a word address, and that counter then advances by one. The address is sized for a memory of 4096 rows, 512 columns and 4 banks, which is 2^23 words. The address and a valid flag appear one clock after the request. A synchronous clear returns every counter to zero, so a new hiding pass can start from a known state.

Top module: `keyshuf_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all counters become zero, `addr_valid` becomes 0 and `addr` becomes 0.
- R2: `addr_valid` is 1 in exactly those cycles that follow a rising edge where `step_req` was 1 and `clear` was 0. Otherwise it is 0.
- R3: The counter is chosen by `key_byte[5:0]` alone. Two keys that differ only in bits 7:6 advance and read the same counter.
- R4: On a valid address, `addr[15:14]` equals `key_byte[7:6]`, `addr[13:8]` equals `key_byte[5:0]`, and `addr[7:0]` equals the selected counter's value before the increment. `addr[22:16]` is zero.
- R5: Each accepted request adds one to the selected counter only. Every other counter keeps its value.
- R6: A counter at 255 that is selected again wraps to 0.
- R7: `clear` zeroes all counters at the next rising edge and takes priority over a request in the same cycle. That request is dropped and `addr_valid` stays 0.
- R8: `addr` holds its last value in every cycle in which no request was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of all pointer counters |
| step_req | input | 1 | Request one address |
| key_byte | input | 8 | Key byte: bits 5:0 pick the counter, bits 7:6 pick the memory bank |
| addr | output | 23 | Memory word address |
| addr_valid | output | 1 | High for one cycle per accepted request |

## Verification
The case that is hardest to reach from the ports is a counter wrapping from 255 back to 0. It needs 256 requests aimed at one counter, and the other counters must be seen to stay put while that happens. The stimulus hammers a single index for more than 256 requests and keeps changing the upper key bits, so the same counter is reached through several aliases. It then revisits other indices and checks that their counts resumed where they had stopped. A clear is also issued together with a request, to show that the clear wins and that the dropped request leaves no trace.

// File: rtl/keyshuf_pkg.sv
package keyshuf_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_STEP  = 2'd2
  } op_e;

  // clear outranks a request in the same cycle
  function automatic op_e decode_op(input logic clr, input logic req);
    if (clr)      return OP_CLEAR;
    else if (req) return OP_STEP;
    else          return OP_IDLE;
  endfunction

endpackage

// File: rtl/ptr_bank.sv
module ptr_bank
  import keyshuf_pkg::*;
#(
  parameter int NUM_PTRS = 64,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NUM_PTRS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  op_e                       op,
  input  logic [IDX_W-1:0]          idx,
  output logic [NUM_PTRS*CNT_W-1:0] cnt_flat
);

  logic [NUM_PTRS-1:0] bump_vec;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
    logic [CNT_W-1:0] cnt_q;
    assign bump_vec[g] = (op == OP_STEP) && (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n || op == OP_CLEAR) cnt_q <= '0;
      else if (bump_vec[g])         cnt_q <= next_count(cnt_q);
    end
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt_q;
  end

  // observation registers for the assertions
  logic             last_step_q, last_clr_q;
  logic [IDX_W-1:0] last_idx_q;
  logic [CNT_W-1:0] last_val_q;
  logic [CNT_W-1:0] observed_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_step_q <= 1'b0;
      last_clr_q  <= 1'b0;
      last_idx_q  <= '0;
      last_val_q  <= '0;
    end else begin
      last_step_q <= (op == OP_STEP);
      last_clr_q  <= (op == OP_CLEAR);
      last_idx_q  <= idx;
      last_val_q  <= cnt_flat[idx*CNT_W +: CNT_W];
    end
  end

  assign observed_now = cnt_flat[last_idx_q*CNT_W +: CNT_W];

  p_step_adds_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_step_q |-> observed_now == CNT_W'(last_val_q + CNT_W'(1)));

  p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step_q && last_val_q == {CNT_W{1'b1}}) |-> observed_now == '0);

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    last_clr_q |-> cnt_flat == '0);

  p_single_bump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bump_vec));

endmodule

// File: rtl/ctr_select.sv
module ctr_select #(
  parameter int NUM_PTRS = 64,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = $clog2(NUM_PTRS)
) (
  input  logic [NUM_PTRS*CNT_W-1:0] cnt_flat,
  input  logic [IDX_W-1:0]          idx,
  output logic [CNT_W-1:0]          picked
);

  logic [CNT_W-1:0] lanes [NUM_PTRS];

  for (genvar g = 0; g < NUM_PTRS; g++) begin : g_lane
    assign lanes[g] = cnt_flat[g*CNT_W +: CNT_W];
  end

  assign picked = lanes[idx];

endmodule

// File: rtl/addr_pack.sv
module addr_pack #(
  parameter int BSEL_W = 2,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 23,
  localparam int FIELD_W = BSEL_W + IDX_W + CNT_W
) (
  input  logic [BSEL_W-1:0] bsel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] addr
);

  // shift the index and bank fields above the count, then zero-extend
  function automatic logic [ADDR_W-1:0] pack_addr(
    input logic [BSEL_W-1:0] b, input logic [IDX_W-1:0] i, input logic [CNT_W-1:0] c);
    logic [FIELD_W-1:0] f;
    f = (FIELD_W'(b) << (IDX_W + CNT_W)) | (FIELD_W'(i) << CNT_W) | FIELD_W'(c);
    return ADDR_W'(f);
  endfunction

  assign addr = pack_addr(bsel, idx, count);

endmodule

// File: rtl/keyshuf_addr_gen.sv
module keyshuf_addr_gen
  import keyshuf_pkg::*;
#(
  parameter int NUM_PTRS = 64,
  parameter int CNT_W    = 8,
  parameter int KEY_W    = 8,
  parameter int ROWS     = 4096,
  parameter int COLS     = 512,
  parameter int BANKS    = 4,
  localparam int IDX_W   = $clog2(NUM_PTRS),
  localparam int BSEL_W  = KEY_W - IDX_W,
  localparam int ADDR_W  = $clog2(ROWS * COLS * BANKS),
  localparam int FIELD_W = BSEL_W + IDX_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_req,
  input  logic [KEY_W-1:0]  key_byte,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_valid
);

  op_e               op;
  logic [IDX_W-1:0]  sel_idx;
  logic [BSEL_W-1:0] sel_bank;
  logic [NUM_PTRS*CNT_W-1:0] cnt_flat;
  logic [CNT_W-1:0]  picked;
  logic [ADDR_W-1:0] addr_next;
  logic              accept;

  assign op       = decode_op(clear, step_req);
  assign sel_idx  = key_byte[IDX_W-1:0];
  assign sel_bank = key_byte[KEY_W-1:IDX_W];
  assign accept   = (op == OP_STEP);

  ptr_bank #(.NUM_PTRS(NUM_PTRS), .CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .op(op), .idx(sel_idx), .cnt_flat(cnt_flat));

  ctr_select #(.NUM_PTRS(NUM_PTRS), .CNT_W(CNT_W)) u_sel (
    .cnt_flat(cnt_flat), .idx(sel_idx), .picked(picked));

  addr_pack #(.BSEL_W(BSEL_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_pack (
    .bsel(sel_bank), .idx(sel_idx), .count(picked), .addr(addr_next));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr       <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_valid <= accept;
      if (accept) addr <= addr_next;
    end
  end

  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !clear) |=> addr_valid);

  p_no_valid_otherwise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_req && !clear) |=> !addr_valid);

  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (addr >> FIELD_W) == '0);

  p_bank_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !clear) |=> addr[FIELD_W-1 -: BSEL_W] == $past(key_byte[KEY_W-1:IDX_W]));

  p_index_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !clear) |=> addr[CNT_W +: IDX_W] == $past(key_byte[IDX_W-1:0]));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> $stable(addr));

endmodule

// File: tb/sim_keyshuf_addr_gen.sv
module sim_keyshuf_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n, clear, step_req;
  logic [7:0]  key_byte;
  logic [22:0] addr;
  logic        addr_valid;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference state
  int m_cnt [64];
  int m_addr;
  bit m_valid;

  always #10 clk = ~clk;

  keyshuf_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .step_req(step_req),
    .key_byte(key_byte), .addr(addr), .addr_valid(addr_valid));

  // reference model updated at each edge from the stable inputs
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_valid = 0;
      m_addr  = 0;
    end else if (clear) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_valid = 0;
    end else if (step_req) begin
      int i;
      i = key_byte % 64;
      m_addr  = (key_byte / 64) * 16384 + i * 256 + m_cnt[i];
      m_valid = 1;
      m_cnt[i] = (m_cnt[i] + 1) % 256;
    end else begin
      m_valid = 0;
    end
  end

  always @(posedge clk) begin
    #5;
    checks++;
    if (addr_valid !== m_valid) begin
      errors++;
      $display("FAIL %s valid actual %0b expected %0b", tag, addr_valid, m_valid);
    end
    checks++;
    if (addr !== 23'(m_addr)) begin
      errors++;
      $display("FAIL %s addr actual %h expected %h", tag, addr, 23'(m_addr));
    end
  end

  task automatic issue(input logic [7:0] k);
    @(negedge clk);
    step_req = 1'b1; clear = 1'b0; key_byte = k;
    @(negedge clk);
    step_req = 1'b0;
  endtask

  task automatic burst(input logic [7:0] k);
    @(negedge clk);
    step_req = 1'b1; clear = 1'b0; key_byte = k;
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      step_req = 1'b0; clear = 1'b0; key_byte = 8'(j * 37);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clear = 1'b0; step_req = 1'b0; key_byte = 8'h00;
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: first requests after reset must see count 0
    issue(8'h00); issue(8'h3F); issue(8'h81);
    // R2/R4: back-to-back and gapped requests across bank and index fields
    tag = "R2";
    for (int j = 0; j < 10; j++) burst(8'(j * 29 + 3));
    idle(2);
    issue(8'hC7); idle(1); issue(8'h47);
    tag = "R4";
    for (int j = 0; j < 16; j++) burst(8'(8'hF0 ^ 8'(j * 11)));
    idle(1);
    // R3: aliases of index 5 share one counter
    tag = "R3";
    issue(8'h05); issue(8'hC5); burst(8'h45); burst(8'h85); burst(8'h05);
    idle(1);
    // R5/R6: drive index 0x2A past 255 through changing bank bits
    tag = "R6";
    for (int j = 0; j < 300; j++) burst(8'(((j % 4) << 6) | 8'h2A));
    idle(1);
    // R5: other counters resumed where they stopped
    tag = "R5";
    issue(8'h05); issue(8'h3F); issue(8'h00); issue(8'h2A);
    // R7: clear, then clear together with a request
    tag = "R7";
    @(negedge clk); clear = 1'b1; step_req = 1'b0;
    @(negedge clk); clear = 1'b1; step_req = 1'b1; key_byte = 8'h2A;
    @(negedge clk); clear = 1'b0; step_req = 1'b0;
    issue(8'h2A); issue(8'h05); issue(8'hFF);
    // R8: long idle with wandering key keeps the address
    tag = "R8";
    idle(12);
    issue(8'h11); idle(6);
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule